// File: doc/BRIEF.md
# BCD Calendar Clock with Time-of-Day Alarm

This block keeps wall-clock time and a calendar in packed BCD registers and advances them by one second for every cycle in which a one-hertz enable pulse is high. The hours register carries its own format selector, so software can run the clock in 12-hour form with an afternoon flag or in 24-hour form. Date, month and year roll over with the correct month lengths, and February gets a 29th day in every year that divides by four.

Four alarm registers hold a second, minute, hour and weekday. Each has a mask bit, and the masks set how often the alarm fires: every second, once a minute, once an hour, once a day or once a week. A match sets a sticky request flag. The interrupt pin follows that flag while the alarm-interrupt enable is set. Any access to an alarm register clears the flag. Software reaches every register through a decoded single-cycle register port with a combinational read path.

Top module: `rtc_calendar_alarm`

## Requirements
- R1: After reset the registers hold seconds 00, minutes 00, hours 00 (24-hour form), weekday 01, date 01, month 01 and year 00. All alarm registers, the control register and the request flag are zero, and `irq_o` is low.
- R2: The register map is: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, A alarm weekday, B control, C status (bit 0 is the request flag, read only). Addresses D to F read zero. Unused bits always read zero: seconds/minutes keep bits 6:0, hours keeps 6:0, weekday keeps 2:0, date keeps 5:0, month keeps 4:0, alarm weekday keeps bits 7 and 2:0, and control keeps bits 7 and 0.
- R3: Seconds and minutes count 00 to 59 in BCD. Seconds wrapping from 59 to 00 advances minutes. Minutes wrapping advances hours.
- R4: With hours bit 6 = 0 (24-hour form) the hours count 00 to 23, with bit 5 as the tens-of-twenty bit. The step from 23 to 00 advances the day.
- R5: With hours bit 6 = 1 (12-hour form) bits 4:0 hold 01 to 12 and bit 5 is the afternoon flag. 11 steps to 12 and toggles the flag. 12 steps to 01 and keeps the flag. Only the step from 11 with the flag set to 12 with the flag clear (midnight) advances the day.
- R6: On a day advance, the weekday steps 1 to 7 and wraps to 1. The date wraps to 01 after the month's last day (31, or 30 for months 04, 06, 09 and 11, and for month 02 either 29 when the year is divisible by 4 or 28 otherwise). The month wraps 12 to 01 and advances the year. The year wraps 99 to 00.
- R7: While control bit 7 is 1, tick pulses leave the time unchanged. Register writes still take effect.
- R8: A tick in the same cycle as a write to any of addresses 0 to 6 is dropped. Only the write takes effect.
- R9: The alarm registers carry a mask in bit 7. A field whose mask is 1 always matches. A field whose mask is 0 matches when alarm bits 6:0 equal the time register's bits 6:0 (for the weekday, bits 2:0). With all masks at 0 the alarm fires once a week. With all masks at 1 it fires on every second.
- R10: The alarm match is evaluated once per accepted tick, on the updated time. The request flag is set on the second clock edge after the tick cycle. `irq_o` is high exactly while the flag is set and control bit 0 is 1.
- R11: A read strobe or a write strobe addressing any of addresses 7 to A clears the request flag. If a set and a clear occur on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (only used to clear the alarm flag) |
| reg_rdata | output | 8 | Combinational read data at `reg_addr` |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with its default four-bit register address, which makes the whole map, including the unused addresses, readable from the port. Because time can be preloaded through writes, a single tick reaches every carry boundary. The bench sweeps every second, every minute and every hour in both hour forms, and every month end of all hundred years, so every month length and every leap February is visited. The alarm checks cover each mask pattern, the enable gating, the clearing accesses and the same-edge set-versus-clear case.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SEC   = 4'h0;
    localparam logic [ADDR_W-1:0] A_MIN   = 4'h1;
    localparam logic [ADDR_W-1:0] A_HOUR  = 4'h2;
    localparam logic [ADDR_W-1:0] A_WDAY  = 4'h3;
    localparam logic [ADDR_W-1:0] A_DATE  = 4'h4;
    localparam logic [ADDR_W-1:0] A_MON   = 4'h5;
    localparam logic [ADDR_W-1:0] A_YEAR  = 4'h6;
    localparam logic [ADDR_W-1:0] A_ASEC  = 4'h7;
    localparam logic [ADDR_W-1:0] A_AMIN  = 4'h8;
    localparam logic [ADDR_W-1:0] A_AHOUR = 4'h9;
    localparam logic [ADDR_W-1:0] A_AWDAY = 4'hA;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'hB;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'hC;

    localparam int ALM_FIELDS = 4;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t date;
        byte_t mon;
        byte_t year;
    } clock_regs_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
    } alarm_regs_t;

    typedef struct packed {
        logic halt;
        logic irq_en;
    } ctrl_t;

    typedef struct packed {
        byte_t hour;
        logic  day_step;
    } hour_step_t;

    function automatic byte_t keep_bits(input logic [ADDR_W-1:0] a);
        case (a)
            A_SEC, A_MIN, A_HOUR:  keep_bits = 8'h7F;
            A_WDAY:                keep_bits = 8'h07;
            A_DATE:                keep_bits = 8'h3F;
            A_MON:                 keep_bits = 8'h1F;
            A_YEAR:                keep_bits = 8'hFF;
            A_ASEC, A_AMIN, A_AHOUR: keep_bits = 8'hFF;
            A_AWDAY:               keep_bits = 8'h87;
            A_CTRL:                keep_bits = 8'h81;
            default:               keep_bits = 8'h00;
        endcase
    endfunction

    function automatic byte_t bcd_inc(input byte_t v);
        if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_year(input byte_t y);
        if (y[4]) leap_year = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      leap_year = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic byte_t month_end(input byte_t m, input byte_t y);
        case (m)
            8'h02:                      month_end = leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
            default:                    month_end = 8'h31;
        endcase
    endfunction

    function automatic hour_step_t next_hour(input byte_t h);
        hour_step_t r;
        r = '0;
        if (h[6]) begin
            if (h[4:0] == 5'h11) begin
                r.hour     = {2'b01, ~h[5], 5'h12};
                r.day_step = h[5];
            end else if (h[4:0] == 5'h12) begin
                r.hour = {2'b01, h[5], 5'h01};
            end else begin
                r.hour = {2'b01, h[5], 5'(bcd_inc({3'b000, h[4:0]}))};
            end
        end else begin
            if (h[5:0] == 6'h23) begin
                r.hour     = 8'h00;
                r.day_step = 1'b1;
            end else begin
                r.hour = {2'b00, 6'(bcd_inc({2'b00, h[5:0]}))};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              halt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    output clock_regs_t       now,
    output logic              tick_done
);

    localparam int NREG = 7;

    clock_regs_t nxt;
    hour_step_t  hs;
    logic        wr_time, step;
    logic        sec_wrap, min_wrap, hr_step, day_step, date_wrap, mon_wrap;

    assign wr_time = wr_en && (wr_addr <= A_YEAR);
    assign step    = tick && !halt && !wr_time;

    always_comb begin
        nxt       = now;
        hs        = next_hour(now.hour);
        sec_wrap  = (now.sec == 8'h59);
        min_wrap  = sec_wrap && (now.min == 8'h59);
        hr_step   = min_wrap;
        day_step  = hr_step && hs.day_step;
        date_wrap = day_step && (now.date == month_end(now.mon, now.year));
        mon_wrap  = date_wrap && (now.mon == 8'h12);

        nxt.sec = sec_wrap ? 8'h00 : bcd_inc(now.sec);
        if (sec_wrap) nxt.min  = (now.min == 8'h59) ? 8'h00 : bcd_inc(now.min);
        if (hr_step)  nxt.hour = hs.hour;
        if (day_step) begin
            nxt.wday = (now.wday == 8'h07) ? 8'h01 : bcd_inc(now.wday);
            nxt.date = (now.date == month_end(now.mon, now.year)) ? 8'h01 : bcd_inc(now.date);
        end
        if (date_wrap) nxt.mon  = (now.mon == 8'h12) ? 8'h01 : bcd_inc(now.mon);
        if (mon_wrap)  nxt.year = (now.year == 8'h99) ? 8'h00 : bcd_inc(now.year);
    end

    // Register file as an array view so writes decode with one generate loop.
    byte_t cur [NREG];
    byte_t inc [NREG];
    assign cur = '{now.sec, now.min, now.hour, now.wday, now.date, now.mon, now.year};
    assign inc = '{nxt.sec, nxt.min, nxt.hour, nxt.wday, nxt.date, nxt.mon, nxt.year};

    localparam byte_t RST_VAL [NREG] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

    byte_t q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= RST_VAL[i];
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                q[i] <= wr_data & keep_bits(ADDR_W'(i));
            else if (step)
                q[i] <= inc[i];
        end
    end

    assign now = '{sec: q[0], min: q[1], hour: q[2], wday: q[3], date: q[4], mon: q[5], year: q[6]};

    always_ff @(posedge clk) begin
        if (rst) tick_done <= 1'b0;
        else     tick_done <= step;
    end

    // R7: halted clock with no write holds every time register
    p_halt_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (halt && !wr_time) |=> $stable(now));

    // R3: seconds wrap to 00 after 59 on an accepted tick
    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt && !wr_time && now.sec == 8'h59) |=> (now.sec == 8'h00));

    // R8: a tick that coincides with a time write leaves seconds alone unless written
    p_write_drops_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_en && wr_addr != A_SEC && wr_addr <= A_YEAR) |=> $stable(now.sec));

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  clock_regs_t       now,
    input  logic              tick_done,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wr_data,
    output alarm_regs_t       alm,
    output logic              flag
);

    byte_t a [ALM_FIELDS];
    byte_t t [ALM_FIELDS];
    byte_t cmp_mask [ALM_FIELDS];
    logic [ALM_FIELDS-1:0] hit;
    logic  in_range, access, match;

    assign t        = '{now.sec, now.min, now.hour, now.wday};
    assign cmp_mask = '{8'h7F, 8'h7F, 8'h7F, 8'h07};
    assign in_range = (addr >= A_ASEC) && (addr <= A_AWDAY);
    assign access   = (wr_en || rd_en) && in_range;

    for (genvar i = 0; i < ALM_FIELDS; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                a[i] <= '0;
            else if (wr_en && addr == A_ASEC + ADDR_W'(i))
                a[i] <= wr_data & keep_bits(A_ASEC + ADDR_W'(i));
        end
        assign hit[i] = a[i][7] || ((a[i] & cmp_mask[i]) == (t[i] & cmp_mask[i]));
    end

    assign match = &hit;
    assign alm   = '{sec: a[0], min: a[1], hour: a[2], wday: a[3]};

    always_ff @(posedge clk) begin
        if (rst)                     flag <= 1'b0;
        else if (tick_done && match) flag <= 1'b1;
        else if (access)             flag <= 1'b0;
    end

    // R10: the flag only rises after an accepted tick
    p_rise_after_tick_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick_done));

    // R11: an alarm register access with no concurrent match clears the flag
    p_access_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (access && !tick_done) |=> !flag);

    // R9: all masks set means every accepted tick raises the flag
    p_every_second_r9: assert property (@(posedge clk) disable iff (rst)
        (tick_done && a[0][7] && a[1][7] && a[2][7] && a[3][7]) |=> flag);

endmodule

// File: rtl/rtc_calendar_alarm.sv
module rtc_calendar_alarm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    clock_regs_t now;
    alarm_regs_t alm;
    ctrl_t       ctrl;
    logic        tick_done, flag;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (reg_wr && reg_addr == A_CTRL)
            ctrl <= '{halt: reg_wdata[7], irq_en: reg_wdata[0]};
    end

    rtc_timekeeper u_time (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_1hz),
        .halt      (ctrl.halt),
        .wr_en     (reg_wr),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .now       (now),
        .tick_done (tick_done)
    );

    rtc_alarm_unit u_alarm (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .tick_done (tick_done),
        .wr_en     (reg_wr),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .wr_data   (reg_wdata),
        .alm       (alm),
        .flag      (flag)
    );

    always_comb begin
        case (reg_addr)
            A_SEC:   reg_rdata = now.sec;
            A_MIN:   reg_rdata = now.min;
            A_HOUR:  reg_rdata = now.hour;
            A_WDAY:  reg_rdata = now.wday;
            A_DATE:  reg_rdata = now.date;
            A_MON:   reg_rdata = now.mon;
            A_YEAR:  reg_rdata = now.year;
            A_ASEC:  reg_rdata = alm.sec;
            A_AMIN:  reg_rdata = alm.min;
            A_AHOUR: reg_rdata = alm.hour;
            A_AWDAY: reg_rdata = alm.wday;
            A_CTRL:  reg_rdata = {ctrl.halt, 6'b0, ctrl.irq_en};
            A_STAT:  reg_rdata = {7'b0, flag};
            default: reg_rdata = '0;
        endcase
    end

    assign irq_o = flag && ctrl.irq_en;

    // R1: nothing is pending in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> !irq_o);

endmodule

// File: tb/tb_rtc_calendar_alarm.sv
module tb_rtc_calendar_alarm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rtc_calendar_alarm dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_strobe(input logic [3:0] a);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] wd, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(4'h0, s); wr(4'h1, m); wr(4'h2, h); wr(4'h3, wd);
        wr(4'h4, dt); wr(4'h5, mo); wr(4'h6, y);
    endtask

    task automatic expect_flag(input string req, input logic f, input logic i);
        logic [7:0] d;
        rd(4'hC, d);
        check(req, d, {7'b0, f});
        check(req, {7'b0, irq_o}, {7'b0, i});
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        begin
            logic [7:0] rv [13];
            rv = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00,
                   8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
            for (int a = 0; a < 13; a++) begin
                rd(4'(a), d);
                check("R1 reset", d, rv[a]);
            end
            check("R1 irq", {7'b0, irq_o}, 8'h00);
        end

        // R2 unused bits and unmapped addresses
        wr(4'h3, 8'hFF); rd(4'h3, d); check("R2 weekday bits", d, 8'h07);
        wr(4'h4, 8'hFF); rd(4'h4, d); check("R2 date bits", d, 8'h3F);
        wr(4'h5, 8'hFF); rd(4'h5, d); check("R2 month bits", d, 8'h1F);
        wr(4'h0, 8'hFF); rd(4'h0, d); check("R2 seconds bits", d, 8'h7F);
        wr(4'hA, 8'hFF); rd(4'hA, d); check("R2 alarm weekday bits", d, 8'h87);
        wr(4'hB, 8'h7E); rd(4'hB, d); check("R2 control bits", d, 8'h00);
        wr(4'hE, 8'hFF); rd(4'hE, d); check("R2 unmapped", d, 8'h00);
        wr(4'hC, 8'hFF); rd(4'hC, d); check("R2 status read only", d, 8'h00);
        wr(4'hA, 8'h00);

        // R3 seconds sweep
        for (int s = 0; s < 60; s++) begin
            set_time(bcd(s), 8'h17, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
            tick();
            rd(4'h0, d); check("R3 seconds", d, bcd((s + 1) % 60));
            rd(4'h1, d); check("R3 minute carry", d, (s == 59) ? 8'h18 : 8'h17);
        end
        // R3 minutes sweep
        for (int m = 0; m < 60; m++) begin
            set_time(8'h59, bcd(m), 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
            tick();
            rd(4'h1, d); check("R3 minutes", d, bcd((m + 1) % 60));
            rd(4'h2, d); check("R3 hour carry", d, (m == 59) ? 8'h06 : 8'h05);
        end

        // R4 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            set_time(8'h59, 8'h59, bcd(h), 8'h03, 8'h10, 8'h03, 8'h21);
            tick();
            rd(4'h2, d); check("R4 hour", d, bcd((h + 1) % 24));
            rd(4'h3, d); check("R4 day advance", d, (h == 23) ? 8'h04 : 8'h03);
        end

        // R5 12-hour sweep
        for (int pm = 0; pm < 2; pm++) begin
            for (int h = 1; h <= 12; h++) begin
                int eh; int ep;
                set_time(8'h59, 8'h59, 8'h40 | (8'(pm) << 5) | bcd(h),
                         8'h03, 8'h10, 8'h03, 8'h21);
                tick();
                eh = (h == 12) ? 1 : h + 1;
                ep = (h == 11) ? 1 - pm : pm;
                rd(4'h2, d); check("R5 12h hour", d, 8'h40 | (8'(ep) << 5) | bcd(eh));
                rd(4'h3, d); check("R5 midnight day", d, (h == 11 && pm == 1) ? 8'h04 : 8'h03);
            end
        end

        // R6 weekday wrap
        for (int w = 1; w <= 7; w++) begin
            set_time(8'h59, 8'h59, 8'h23, bcd(w), 8'h10, 8'h03, 8'h21);
            tick();
            rd(4'h3, d); check("R6 weekday", d, bcd((w % 7) + 1));
        end

        // R6 month ends over every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int ld;
                ld = mdays(m, y);
                set_time(8'h59, 8'h59, 8'h23, 8'h01, bcd(ld), bcd(m), bcd(y));
                tick();
                rd(4'h4, d); check("R6 date wrap", d, 8'h01);
                rd(4'h5, d); check("R6 month", d, bcd((m % 12) + 1));
                rd(4'h6, d); check("R6 year", d, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
                if (m == 2) begin
                    set_time(8'h59, 8'h59, 8'h23, 8'h01, bcd(ld - 1), 8'h02, bcd(y));
                    tick();
                    rd(4'h4, d); check("R6 february last day", d, bcd(ld));
                end
            end
        end

        // R7 halt
        set_time(8'h30, 8'h10, 8'h08, 8'h02, 8'h05, 8'h06, 8'h22);
        wr(4'hB, 8'h80);
        tick(); tick();
        rd(4'h0, d); check("R7 halted seconds", d, 8'h30);
        wr(4'h1, 8'h44);
        rd(4'h1, d); check("R7 write while halted", d, 8'h44);
        wr(4'hB, 8'h00);
        tick();
        rd(4'h0, d); check("R7 resumed", d, 8'h31);

        // R8 write with concurrent tick
        @(negedge clk);
        reg_addr = 4'h6; reg_wdata = 8'h42; reg_wr = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_1hz = 1'b0;
        rd(4'h0, d); check("R8 tick dropped", d, 8'h31);
        rd(4'h6, d); check("R8 write kept", d, 8'h42);

        // R9/R10 every-second alarm
        wr(4'h7, 8'h80); wr(4'h8, 8'h80); wr(4'h9, 8'h80); wr(4'hA, 8'h80);
        wr(4'hB, 8'h01);
        expect_flag("R11 cleared by write", 1'b0, 1'b0);
        tick();
        expect_flag("R9 every second", 1'b1, 1'b1);
        rd_strobe(4'h9);
        expect_flag("R11 cleared by read", 1'b0, 1'b0);
        wr(4'hB, 8'h00);
        tick();
        expect_flag("R10 enable gates irq", 1'b1, 1'b0);
        wr(4'hB, 8'h01);
        check("R10 irq follows enable", {7'b0, irq_o}, 8'h01);

        // R10 timing: flag set on second edge after tick cycle
        rd_strobe(4'h7);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        #1 check("R10 not yet set", {7'b0, irq_o}, 8'h00);
        @(negedge clk);
        #1 check("R10 set two edges later", {7'b0, irq_o}, 8'h01);

        // R11 set wins over same-edge clear
        rd_strobe(4'h7);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0; reg_addr = 4'h8; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        expect_flag("R11 set wins", 1'b1, 1'b1);

        // R9 seconds match only
        wr(4'h7, 8'h30);
        set_time(8'h28, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        rd_strobe(4'h7);
        tick(); expect_flag("R9 second 29 no match", 1'b0, 1'b0);
        tick(); expect_flag("R9 second 30 match", 1'b1, 1'b1);
        rd_strobe(4'h7);
        tick(); expect_flag("R9 second 31 no match", 1'b0, 1'b0);

        // R9 weekly alarm
        wr(4'h7, 8'h10); wr(4'h8, 8'h05); wr(4'h9, 8'h08); wr(4'hA, 8'h03);
        set_time(8'h09, 8'h05, 8'h08, 8'h04, 8'h01, 8'h01, 8'h00);
        rd_strobe(4'h7);
        tick(); expect_flag("R9 weekly wrong day", 1'b0, 1'b0);
        set_time(8'h09, 8'h05, 8'h08, 8'h03, 8'h01, 8'h01, 8'h00);
        tick(); expect_flag("R9 weekly match", 1'b1, 1'b1);
        // R9 daily: day masked
        rd_strobe(4'hA);
        wr(4'hA, 8'h80);
        set_time(8'h09, 8'h05, 8'h08, 8'h06, 8'h01, 8'h01, 8'h00);
        tick(); expect_flag("R9 daily match", 1'b1, 1'b1);
        // R9 hour mismatch with day masked
        rd_strobe(4'hA);
        set_time(8'h09, 8'h05, 8'h09, 8'h06, 8'h01, 8'h01, 8'h00);
        tick(); expect_flag("R9 daily wrong hour", 1'b0, 1'b0);
        // R9 hourly: day and hour masked
        wr(4'h9, 8'h80);
        rd_strobe(4'h9);
        tick(); expect_flag("R9 hourly after write", 1'b0, 1'b0);
        set_time(8'h09, 8'h05, 8'h13, 8'h06, 8'h01, 8'h01, 8'h00);
        tick(); expect_flag("R9 hourly match", 1'b1, 1'b1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule